// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a PLL through a safe change of its pre-divider, multiplier and post-divider. A one-cycle start strobe captures the three requested values. The block then parks the PLL in bypass and holds it in reset while the new encoded divider and multiplier words are applied. It releases reset, waits for lock, and finally switches the PLL output back in. Every wait is a down-count of reference-clock cycles. The bypass and reset waits come from parameters. The lock wait is derived from the requested pre-divider.

The control lines driven to the PLL are an output enable, an enable-source select, an active-low reset and a power-down. The encoded configuration words are driven beside them. A busy flag covers the whole sequence, and a single-cycle done pulse marks its end. Three factor outputs report the effective pre-division, multiplication and post-division that the PLL currently applies. Software or a neighbour block can combine these with the input frequency to obtain the output rate.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the control lines are enable 0, enable-source 1, active-low reset 1 and power-down 1. All configuration words are 0, busy and done are 0, and all three factor outputs are 1.
- R2: A start strobe seen while idle raises busy and clears enable and enable-source on the next edge. The PLL then stays in bypass, with active-low reset still 1 and the configuration words unchanged, for BYPASS_CYC+1 cycles.
- R3: At the end of bypass, active-low reset and power-down both drop on one edge. The new configuration words appear on that same edge, and this reset phase lasts RESET_CYC+1 cycles. Configuration words change only while active-low reset is 0.
- R4: A divider word is REQ_W+1 bits wide, with bit REQ_W as its enable. A requested value of 0 gives the word 0 (divider off). A value v from 1 up gives enable 1 with v-1 in bits REQ_W-1:0.
- R5: The multiplier word is v-1 for a request v of 1 or more, and 0 for a request of 0, which means multiply by one.
- R6: After reset release, the lock wait lasts L+1 cycles. L is LOCK_PER_DIV times the requested pre-divider (default 20), or LOCK_DEFAULT_CYC (default 50) when the request is 0.
- R7: At the end of the lock wait, enable rises and busy falls on the same edge. Done is high for exactly the first cycle with enable high. Busy lasts BYPASS_CYC+RESET_CYC+L+3 cycles in all.
- R8: A start strobe while busy is ignored: neither the sequence length nor the words applied change.
- R9: While enable is 0, all factor outputs are 1. While enable is 1, each divider factor is its ratio field plus one if its enable bit is set, otherwise 1. The multiplier factor is the word plus one.
- R10: With a divider absent (HAS_PREDIV or HAS_POSTDIV set to 0), its word stays 0 and its factor stays 1. The lock wait is still derived from the requested pre-divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| prediv_i | input | REQ_W | Requested pre-divider (0 = off) |
| mult_i | input | REQ_W | Requested multiplier (0 = x1) |
| postdiv_i | input | REQ_W | Requested post-divider (0 = off) |
| pll_en_o | output | 1 | PLL output enable (0 = bypass) |
| pll_en_src_o | output | 1 | Enable-source select |
| pll_nrst_o | output | 1 | PLL reset, active low |
| pll_pwrdn_o | output | 1 | PLL power-down |
| prediv_reg_o | output | REQ_W+1 | Encoded pre-divider word |
| mult_reg_o | output | REQ_W | Encoded multiplier word |
| postdiv_reg_o | output | REQ_W+1 | Encoded post-divider word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| eff_prediv_o | output | REQ_W+1 | Effective pre-division factor |
| eff_mult_o | output | REQ_W+1 | Effective multiplication factor |
| eff_postdiv_o | output | REQ_W+1 | Effective post-division factor |

## Verification
On every cycle the assertions check the following. Busy implies bypass. Configuration words move only while the PLL is held in reset. Enable rises only with reset released and power on. Done is a lone pulse right after busy. Captured requests stay frozen while busy, and an idle delay counter stays idle. What only the bench scenarios show is the exact phase lengths, including the lock wait for each pre-divider. They also show the encoded words for the zero and maximum requests, the decoded factors after enable, and that a start strobe in mid-sequence leaves the result untouched. A second instance shows the effect of an absent post-divider.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BYPASS = 2'd1,
    ST_RESET  = 2'd2,
    ST_LOCK   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pll_div_encoder.sv
module pll_div_encoder #(
  parameter int REQ_W = 5
) (
  input  logic [REQ_W-1:0] val_i,
  output logic [REQ_W:0]   enc_o
);
  // R4: zero leaves divider off; otherwise enable bit plus ratio v-1
  always_comb begin
    if (val_i == '0) enc_o = '0;
    else             enc_o = {1'b1, val_i - REQ_W'(1)};
  end
endmodule

// File: rtl/pll_delay_counter.sv
module pll_delay_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R6: an expired counter stays expired until reloaded
  a_r6_cnt_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int REQ_W            = 5,
  parameter int CNT_W            = 16,
  parameter int BYPASS_CYC       = 4,
  parameter int RESET_CYC        = 6,
  parameter int LOCK_DEFAULT_CYC = 50,
  parameter int LOCK_PER_DIV     = 20,
  parameter bit HAS_PREDIV       = 1'b1,
  parameter bit HAS_POSTDIV      = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REQ_W-1:0] prediv_i,
  input  logic [REQ_W-1:0] mult_i,
  input  logic [REQ_W-1:0] postdiv_i,
  output logic             pll_en_o,
  output logic             pll_en_src_o,
  output logic             pll_nrst_o,
  output logic             pll_pwrdn_o,
  output logic [REQ_W:0]   prediv_reg_o,
  output logic [REQ_W-1:0] mult_reg_o,
  output logic [REQ_W:0]   postdiv_reg_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [REQ_W:0]   eff_prediv_o,
  output logic [REQ_W:0]   eff_mult_o,
  output logic [REQ_W:0]   eff_postdiv_o
);
  localparam int FW = REQ_W + 1;

  seq_state_e       state_q;
  logic [REQ_W-1:0] req_pre_q, req_mult_q, req_post_q;
  logic [REQ_W:0]   pre_enc, post_enc;
  logic [REQ_W-1:0] mult_enc;
  logic             cnt_load, cnt_zero, cfg_wr;
  logic [CNT_W-1:0] cnt_val, lock_cyc;

  pll_div_encoder #(.REQ_W(REQ_W)) u_pre_enc  (.val_i(req_pre_q),  .enc_o(pre_enc));
  pll_div_encoder #(.REQ_W(REQ_W)) u_post_enc (.val_i(req_post_q), .enc_o(post_enc));

  assign mult_enc = (req_mult_q == '0) ? '0 : req_mult_q - REQ_W'(1);
  assign lock_cyc = (req_pre_q == '0) ? CNT_W'(LOCK_DEFAULT_CYC)
                                      : CNT_W'(LOCK_PER_DIV) * CNT_W'(req_pre_q);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE:   if (start_i)  begin cnt_load = 1'b1; cnt_val = CNT_W'(BYPASS_CYC); end
      ST_BYPASS: if (cnt_zero) begin cnt_load = 1'b1; cnt_val = CNT_W'(RESET_CYC);  end
      ST_RESET:  if (cnt_zero) begin cnt_load = 1'b1; cnt_val = lock_cyc;           end
      default: ;
    endcase
  end

  assign cfg_wr = (state_q == ST_BYPASS) && cnt_zero;

  pll_delay_counter #(.CNT_W(CNT_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      req_pre_q    <= '0;
      req_mult_q   <= '0;
      req_post_q   <= '0;
      pll_en_o     <= 1'b0;
      pll_en_src_o <= 1'b1;
      pll_nrst_o   <= 1'b1;
      pll_pwrdn_o  <= 1'b1;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          req_pre_q    <= prediv_i;
          req_mult_q   <= mult_i;
          req_post_q   <= postdiv_i;
          pll_en_o     <= 1'b0;
          pll_en_src_o <= 1'b0;
          busy_o       <= 1'b1;
          state_q      <= ST_BYPASS;
        end
        ST_BYPASS: if (cnt_zero) begin
          pll_nrst_o  <= 1'b0;
          pll_pwrdn_o <= 1'b0;
          state_q     <= ST_RESET;
        end
        ST_RESET: if (cnt_zero) begin
          pll_nrst_o <= 1'b1;
          state_q    <= ST_LOCK;
        end
        ST_LOCK: if (cnt_zero) begin
          pll_en_o <= 1'b1;
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // configuration words, written once on entry to reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mult_reg_o <= '0;
    else if (cfg_wr) mult_reg_o <= mult_enc;
  end

  generate
    if (HAS_PREDIV) begin : g_pre
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     prediv_reg_o <= '0;
        else if (cfg_wr) prediv_reg_o <= pre_enc;
      end
    end else begin : g_no_pre
      assign prediv_reg_o = '0;
    end
    if (HAS_POSTDIV) begin : g_post
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     postdiv_reg_o <= '0;
        else if (cfg_wr) postdiv_reg_o <= post_enc;
      end
    end else begin : g_no_post
      assign postdiv_reg_o = '0;
    end
  endgenerate

  // R9: effective factors, unity in bypass
  always_comb begin
    eff_prediv_o  = FW'(1);
    eff_mult_o    = FW'(1);
    eff_postdiv_o = FW'(1);
    if (pll_en_o) begin
      eff_mult_o = {1'b0, mult_reg_o} + FW'(1);
      if (prediv_reg_o[REQ_W])
        eff_prediv_o = {1'b0, prediv_reg_o[REQ_W-1:0]} + FW'(1);
      if (postdiv_reg_o[REQ_W])
        eff_postdiv_o = {1'b0, postdiv_reg_o[REQ_W-1:0]} + FW'(1);
    end
  end

  a_r2_busy_in_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !pll_en_o && !pll_en_src_o);

  a_r3_mult_only_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mult_reg_o) |-> !pll_nrst_o);

  a_r3_prediv_only_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prediv_reg_o) |-> !pll_nrst_o);

  a_r7_enable_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> pll_nrst_o && !pll_pwrdn_o);

  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pll_en_o && !busy_o && $past(busy_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_request_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(req_pre_q) && $stable(req_mult_q) && $stable(req_post_q));
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B = 4;
  localparam int R = 6;

  typedef struct packed {
    logic [4:0] pre, mul, post;
    logic [5:0] epre;
    logic [4:0] emul;
    logic [5:0] epost;
    logic [9:0] lock;
    logic [5:0] fpre, fmul, fpost;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{5'd2,  5'd10, 5'd1,  6'd33, 5'd9,  6'd32, 10'd40,  6'd2,  6'd10, 6'd1},
    '{5'd0,  5'd0,  5'd0,  6'd0,  5'd0,  6'd0,  10'd50,  6'd1,  6'd1,  6'd1},
    '{5'd1,  5'd20, 5'd3,  6'd32, 5'd19, 6'd34, 10'd20,  6'd1,  6'd20, 6'd3},
    '{5'd31, 5'd31, 5'd31, 6'd62, 5'd30, 6'd62, 10'd620, 6'd31, 6'd31, 6'd31},
    '{5'd4,  5'd1,  5'd0,  6'd35, 5'd0,  6'd0,  10'd80,  6'd4,  6'd1,  6'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] pre_in = '0, mul_in = '0, post_in = '0;
  logic en, en_src, nrst, pwrdn, busy, done;
  logic [5:0] pre_reg, post_reg, f_pre, f_mul, f_post;
  logic [4:0] mul_reg;
  logic np_en, np_en_src, np_nrst, np_pwrdn, np_busy, np_done;
  logic [5:0] np_pre_reg, np_post_reg, np_f_pre, np_f_mul, np_f_post;
  logic [4:0] np_mul_reg;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_reprog_seq u_pll_reprog_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .prediv_i(pre_in), .mult_i(mul_in), .postdiv_i(post_in),
    .pll_en_o(en), .pll_en_src_o(en_src), .pll_nrst_o(nrst), .pll_pwrdn_o(pwrdn),
    .prediv_reg_o(pre_reg), .mult_reg_o(mul_reg), .postdiv_reg_o(post_reg),
    .busy_o(busy), .done_o(done),
    .eff_prediv_o(f_pre), .eff_mult_o(f_mul), .eff_postdiv_o(f_post)
  );

  pll_reprog_seq #(.HAS_POSTDIV(1'b0)) u_pll_reprog_seq_nopost (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .prediv_i(pre_in), .mult_i(mul_in), .postdiv_i(post_in),
    .pll_en_o(np_en), .pll_en_src_o(np_en_src), .pll_nrst_o(np_nrst), .pll_pwrdn_o(np_pwrdn),
    .prediv_reg_o(np_pre_reg), .mult_reg_o(np_mul_reg), .postdiv_reg_o(np_post_reg),
    .busy_o(np_busy), .done_o(np_done),
    .eff_prediv_o(np_f_pre), .eff_mult_o(np_f_mul), .eff_postdiv_o(np_f_post)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one sequence; optional stray start at busy sample inj_at with values inj
  task automatic run_seq(input vec_t v, input int inj_at, input logic [4:0] inj);
    int n_byp = 0, n_rst = 0, n_lock = 0, n_busy = 0;
    logic seen_rst = 1'b0, byp_ok = 1'b1, rst_ok = 1'b1, fac_ok = 1'b1, first = 1'b1;
    logic [5:0] old_pre = pre_reg, old_post = post_reg;
    logic [4:0] old_mul = mul_reg;
    @(negedge clk);
    pre_in = v.pre; mul_in = v.mul; post_in = v.post; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n_busy < 2000) begin
      if (n_busy == inj_at) begin
        pre_in = inj; mul_in = inj; post_in = inj; start = 1'b1;
      end else start = 1'b0;
      if (en || en_src) byp_ok = 1'b0;
      if (f_pre != 6'd1 || f_mul != 6'd1 || f_post != 6'd1) fac_ok = 1'b0;
      if (!nrst) begin
        seen_rst = 1'b1; n_rst++;
        if (pwrdn) rst_ok = 1'b0;
        if (first && (pre_reg != v.epre || mul_reg != v.emul || post_reg != v.epost)) rst_ok = 1'b0;
        first = 1'b0;
      end else if (!seen_rst) begin
        n_byp++;
        if (pre_reg != old_pre || mul_reg != old_mul || post_reg != old_post) byp_ok = 1'b0;
      end else n_lock++;
      n_busy++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 bypass lines and words", byp_ok, byp_ok, 1);
    chk("R2 bypass length", n_byp == B + 1, n_byp, B + 1);
    chk("R3 reset length", n_rst == R + 1, n_rst, R + 1);
    chk("R3 words on reset entry, powered", rst_ok, rst_ok, 1);
    chk("R6 lock length", n_lock == int'(v.lock) + 1, n_lock, int'(v.lock) + 1);
    chk("R7 busy length", n_busy == B + R + int'(v.lock) + 3, n_busy, B + R + int'(v.lock) + 3);
    chk("R9 unity factors in bypass", fac_ok, fac_ok, 1);
    chk("R7 enable and done at end", en && done && !busy, {en, done, busy}, 3'b110);
    chk("R4 prediv word", pre_reg == v.epre, pre_reg, v.epre);
    chk("R5 mult word", mul_reg == v.emul, mul_reg, v.emul);
    chk("R4 postdiv word", post_reg == v.epost, post_reg, v.epost);
    chk("R9 prediv factor", f_pre == v.fpre, f_pre, v.fpre);
    chk("R9 mult factor", f_mul == v.fmul, f_mul, v.fmul);
    chk("R9 postdiv factor", f_post == v.fpost, f_post, v.fpost);
    @(negedge clk);
    chk("R7 done single cycle", !done && en, {done, en}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 control lines", {en, en_src, nrst, pwrdn} == 4'b0111, {en, en_src, nrst, pwrdn}, 4'b0111);
    chk("R1 words zero", pre_reg == 0 && mul_reg == 0 && post_reg == 0, pre_reg + mul_reg + post_reg, 0);
    chk("R1 busy/done low", !busy && !done, {busy, done}, 0);
    chk("R1 unity factors", f_pre == 1 && f_mul == 1 && f_post == 1, {f_pre, f_mul, f_post}, {6'd1, 6'd1, 6'd1});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      run_seq(VECS[i], -1, 5'd0);
      if (i == 3) begin
        // R10: absent post-divider
        chk("R10 absent postdiv word", np_post_reg == 0, np_post_reg, 0);
        chk("R10 absent postdiv factor", np_f_post == 1, np_f_post, 1);
        chk("R10 prediv still applied", np_f_pre == 6'd31 && np_en, np_f_pre, 31);
      end
    end

    // R8: stray start in mid-sequence
    run_seq('{5'd3, 5'd5, 5'd2, 6'd34, 5'd4, 6'd33, 10'd60, 6'd3, 6'd5, 6'd2}, 10, 5'd7);
    run_seq('{5'd3, 5'd5, 5'd2, 6'd34, 5'd4, 6'd33, 10'd60, 6'd3, 6'd5, 6'd2}, 30, 5'd9);
    chk("R8 no restart after stray start", !busy, busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule